// File: doc/BRIEF.md
# USB Endpoint Interrupt Event Generator

This block sits beside the serial interface engine of a low-speed USB device. It turns that engine's one-cycle transaction and handshake strobes into interrupt requests for two endpoints. Endpoint 0 is the control endpoint and endpoint 1 is a non-control endpoint. Packet decoding, CRC checking and FIFO storage happen upstream and arrive here only as strobes. A CRC-good qualifier comes with each OUT data strobe, together with a per-endpoint flag that says the endpoint is in its ACK-OUT mode.

An 8-bit enable register gates each source:
- Bit 0 gates every endpoint 0 source.
- Bit 1 gates the IN-direction sources of endpoint 1.
- Bit 2 gates the OUT-direction sources of endpoint 1.
- Bits 7:3 are reserved and read back as zero.

Each qualified event sets a pending flag for its endpoint. The flag stays set until firmware clears it with a write-one-to-clear pulse.

Top module: `usb_ep_irq_gen`

## Requirements
- R1: After synchronous reset, `en_rd_data` reads 0x00 and both bits of `irq_pend` are 0.
- R2: A cycle with `en_wr` high loads bits 2:0 of `en_wr_data` into the enable register. Bits 7:3 of `en_rd_data` always read 0, whatever was written.
- R3: With enable bit 0 set, a SETUP-accepted strobe (`ev_setup`) or a status-stage zero-length-packet strobe (`ev_zlp`) sets `irq_pend[0]`.
- R4: An OUT data strobe `ev_out[i]` sets the endpoint's flag when `ev_crc_ok[i]` is high. When the CRC is bad, it sets the flag only if `ack_out_mode[i]` is high. Endpoint 0 is gated by enable bit 0 and endpoint 1 by enable bit 2.
- R5: A NAK/STALL answer to a host IN (`ev_nak_in[i]`) or to a host OUT (`ev_nak_out[i]`) sets the flag. For endpoint 0 the gate is bit 0. For endpoint 1 the IN answer is gated by bit 1 and the OUT answer by bit 2.
- R6: With enable bit 1 set, an ACK received after a successful IN (`ev_in_ack`) sets `irq_pend[1]`. Endpoint 0 has no such source.
- R7: An event whose enable bit is clear leaves the pending flag unchanged.
- R8: A set pending flag holds until `irq_clr[i]` is high. A clear acts only on its own endpoint.
- R9: When a qualified event and a clear for the same endpoint fall in the same cycle, the flag is set after that cycle.
- R10: The flag rises at the clock edge that ends the event's cycle. The event is qualified by the enable value held before that edge, so a write in the same cycle does not apply to it.
- R11: Several events on one endpoint, whether in one cycle or in successive cycles, leave a single flag, and one clear removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr | input | 1 | Enable register write strobe |
| en_wr_data | input | 8 | Enable register write data |
| en_rd_data | output | 8 | Enable register read value |
| ev_setup | input | 1 | EP0 accepted a SETUP token |
| ev_zlp | input | 1 | EP0 sent a zero-length status packet |
| ev_out | input | 2 | Host OUT data written to endpoint FIFO, per endpoint |
| ev_crc_ok | input | 2 | OUT data had a valid CRC, per endpoint |
| ack_out_mode | input | 2 | Endpoint is in ACK-OUT mode |
| ev_nak_in | input | 2 | NAK/STALL sent to a host IN, per endpoint |
| ev_nak_out | input | 2 | NAK/STALL sent to a host OUT, per endpoint |
| ev_in_ack | input | 1 | EP1 received ACK after an IN |
| irq_clr | input | 2 | Write-one-to-clear for pending flags |
| irq_pend | output | 2 | Pending interrupt flags, bit i for endpoint i |

## Verification
The bench goes after several corner cases, each of which a wrong design would show in a distinct way:
- **Bad-CRC OUT packet, with and without ACK-OUT mode.** A design that ignored the mode flag would either miss the interrupt or raise one on corrupt data.
- **Split endpoint 1 enables.** An IN-side source is fired with only the OUT-side bit set, and the reverse. A design that merged or swapped bits 1 and 2 would raise a flag where none is due.
- **Event and clear in the same cycle, and an enable write in the same cycle as an event.** A design with the wrong priority would drop the interrupt. A design that bypassed the new enable would gate the event with the wrong value.
- **Random mixes of events, clears and writes.** These expose a clear that leaks into the other endpoint, or reserved bits that read back non-zero.

// File: rtl/usb_ep_irq_pkg.sv
package usb_ep_irq_pkg;

  localparam int NUM_EP      = 2;
  localparam int EN_W        = 8;
  localparam int EN_USED     = 3;
  localparam int EP0_EN_BIT  = 0;
  localparam int EP1_IN_BIT  = 1;
  localparam int EP1_OUT_BIT = 2;

  // One endpoint's worth of qualified-or-not event strobes
  typedef struct packed {
    logic setup;
    logic zlp;
    logic out_pkt;
    logic crc_ok;
    logic ack_out;
    logic nak_in;
    logic nak_out;
    logic in_ack;
  } ep_evt_t;

endpackage

// File: rtl/usb_ep_irq_enreg.sv
module usb_ep_irq_enreg #(
  parameter int W    = 8,
  parameter int USED = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MASK = {{(W-USED){1'b0}}, {USED{1'b1}}};

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (wr) q <= wdata & MASK;
  end
endmodule

// File: rtl/usb_ep_irq_qual.sv
module usb_ep_irq_qual
  import usb_ep_irq_pkg::*;
(
  input  ep_evt_t ev,
  input  logic    en_in,
  input  logic    en_out,
  output logic    trig
);
  logic out_take;
  logic in_side;
  logic out_side;

  always_comb begin
    out_take = ev.out_pkt & (ev.crc_ok | ev.ack_out);
    in_side  = ev.setup | ev.zlp | ev.nak_in | ev.in_ack;
    out_side = out_take | ev.nak_out;
    trig     = (en_in & in_side) | (en_out & out_side);
  end
endmodule

// File: rtl/usb_ep_irq_pend.sv
module usb_ep_irq_pend #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)          pend[i] <= 1'b0;
      else if (trig[i]) pend[i] <= 1'b1;
      else if (clr[i])  pend[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_ep_irq_gen.sv
module usb_ep_irq_gen
  import usb_ep_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en_wr,
  input  logic [EN_W-1:0]   en_wr_data,
  output logic [EN_W-1:0]   en_rd_data,
  input  logic              ev_setup,
  input  logic              ev_zlp,
  input  logic [NUM_EP-1:0] ev_out,
  input  logic [NUM_EP-1:0] ev_crc_ok,
  input  logic [NUM_EP-1:0] ack_out_mode,
  input  logic [NUM_EP-1:0] ev_nak_in,
  input  logic [NUM_EP-1:0] ev_nak_out,
  input  logic              ev_in_ack,
  input  logic [NUM_EP-1:0] irq_clr,
  output logic [NUM_EP-1:0] irq_pend
);
  logic [EN_W-1:0]   en_q;
  logic [NUM_EP-1:0] trig;

  usb_ep_irq_enreg #(.W(EN_W), .USED(EN_USED)) u_enreg (
    .clk   (clk),
    .rst   (rst),
    .wr    (en_wr),
    .wdata (en_wr_data),
    .q     (en_q)
  );

  assign en_rd_data = en_q;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    ep_evt_t ev;
    logic    gate_in;
    logic    gate_out;

    if (i == 0) begin : g_ctrl
      // control endpoint: SETUP and status ZLP, one enable for all
      assign ev.setup  = ev_setup;
      assign ev.zlp    = ev_zlp;
      assign ev.in_ack = 1'b0;
      assign gate_in   = en_q[EP0_EN_BIT];
      assign gate_out  = en_q[EP0_EN_BIT];
    end else begin : g_data
      // non-control endpoint: IN ack source, split direction enables
      assign ev.setup  = 1'b0;
      assign ev.zlp    = 1'b0;
      assign ev.in_ack = ev_in_ack;
      assign gate_in   = en_q[EP1_IN_BIT];
      assign gate_out  = en_q[EP1_OUT_BIT];
    end

    assign ev.out_pkt = ev_out[i];
    assign ev.crc_ok  = ev_crc_ok[i];
    assign ev.ack_out = ack_out_mode[i];
    assign ev.nak_in  = ev_nak_in[i];
    assign ev.nak_out = ev_nak_out[i];

    usb_ep_irq_qual u_qual (
      .ev     (ev),
      .en_in  (gate_in),
      .en_out (gate_out),
      .trig   (trig[i])
    );
  end

  usb_ep_irq_pend #(.N(NUM_EP)) u_pend (
    .clk  (clk),
    .rst  (rst),
    .trig (trig),
    .clr  (irq_clr),
    .pend (irq_pend)
  );
endmodule

// File: rtl/usb_ep_irq_gen_chk.sv
module usb_ep_irq_gen_chk
  import usb_ep_irq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [EN_W-1:0]   en_rd_data,
  input logic              ev_setup,
  input logic [NUM_EP-1:0] ev_out,
  input logic [NUM_EP-1:0] ev_crc_ok,
  input logic              ev_in_ack,
  input logic [NUM_EP-1:0] irq_clr,
  input logic [NUM_EP-1:0] irq_pend
);
  // R2: reserved enable bits never read as one
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    en_rd_data[EN_W-1:EN_USED] == '0);

  // R3: enabled SETUP raises EP0 flag on next edge
  p_setup_sets_r3: assert property (@(posedge clk) disable iff (rst)
    en_rd_data[EP0_EN_BIT] && ev_setup |=> irq_pend[0]);

  // R4: enabled good-CRC OUT raises EP0 flag
  p_good_out_r4: assert property (@(posedge clk) disable iff (rst)
    en_rd_data[EP0_EN_BIT] && ev_out[0] && ev_crc_ok[0] |=> irq_pend[0]);

  // R6: enabled IN ack raises EP1 flag
  p_in_ack_r6: assert property (@(posedge clk) disable iff (rst)
    en_rd_data[EP1_IN_BIT] && ev_in_ack |=> irq_pend[1]);

  // R7: all gates closed keeps a clear flag clear
  p_ep0_gated_r7: assert property (@(posedge clk) disable iff (rst)
    !irq_pend[0] && !en_rd_data[EP0_EN_BIT] |=> !irq_pend[0]);
  p_ep1_gated_r7: assert property (@(posedge clk) disable iff (rst)
    !irq_pend[1] && !en_rd_data[EP1_IN_BIT] && !en_rd_data[EP1_OUT_BIT] |=> !irq_pend[1]);

  // R8: without a clear a set flag stays set
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    irq_pend[0] && !irq_clr[0] |=> irq_pend[0]);
  p_hold1_r8: assert property (@(posedge clk) disable iff (rst)
    irq_pend[1] && !irq_clr[1] |=> irq_pend[1]);
endmodule

bind usb_ep_irq_gen usb_ep_irq_gen_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .en_rd_data (en_rd_data),
  .ev_setup   (ev_setup),
  .ev_out     (ev_out),
  .ev_crc_ok  (ev_crc_ok),
  .ev_in_ack  (ev_in_ack),
  .irq_clr    (irq_clr),
  .irq_pend   (irq_pend)
);

// File: tb/usb_ep_irq_gen_tb.sv
module usb_ep_irq_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_wr = 1'b0;
  logic [7:0] en_wr_data = '0;
  logic [7:0] en_rd_data;
  logic       ev_setup = 1'b0, ev_zlp = 1'b0, ev_in_ack = 1'b0;
  logic [1:0] ev_out = '0, ev_crc_ok = '0, ack_out_mode = '0;
  logic [1:0] ev_nak_in = '0, ev_nak_out = '0, irq_clr = '0;
  logic [1:0] irq_pend;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [7:0] m_en   = '0;
  logic [1:0] m_pend = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_ep_irq_gen u_dut (
    .clk(clk), .rst(rst), .en_wr(en_wr), .en_wr_data(en_wr_data),
    .en_rd_data(en_rd_data), .ev_setup(ev_setup), .ev_zlp(ev_zlp),
    .ev_out(ev_out), .ev_crc_ok(ev_crc_ok), .ack_out_mode(ack_out_mode),
    .ev_nak_in(ev_nak_in), .ev_nak_out(ev_nak_out), .ev_in_ack(ev_in_ack),
    .irq_clr(irq_clr), .irq_pend(irq_pend)
  );

  // expected triggers from the requirements (R3..R7)
  function automatic logic [1:0] exp_trig(input logic [7:0] en);
    logic [1:0] t;
    logic       ok0, ok1;
    ok0  = ev_out[0] & (ev_crc_ok[0] | ack_out_mode[0]);
    ok1  = ev_out[1] & (ev_crc_ok[1] | ack_out_mode[1]);
    t[0] = en[0] & (ev_setup | ev_zlp | ok0 | ev_nak_in[0] | ev_nak_out[0]);
    t[1] = (en[1] & (ev_nak_in[1] | ev_in_ack)) | (en[2] & (ok1 | ev_nak_out[1]));
    return t;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    en_wr = 0; en_wr_data = '0; ev_setup = 0; ev_zlp = 0; ev_in_ack = 0;
    ev_out = '0; ev_crc_ok = '0; ev_nak_in = '0; ev_nak_out = '0; irq_clr = '0;
  endtask

  // apply current inputs for one cycle, advance model, compare at next negedge
  task automatic step(input string tag);
    m_pend = exp_trig(m_en) | (m_pend & ~irq_clr);
    if (en_wr) m_en = en_wr_data & 8'h07;
    @(posedge clk);
    @(negedge clk);
    check({tag, " pend"}, {6'b0, irq_pend}, {6'b0, m_pend});
    check({tag, " en"}, en_rd_data, m_en);
    quiet();
  endtask

  task automatic wr_en(input logic [7:0] v);
    en_wr = 1; en_wr_data = v; step("R2 write");
  endtask

  task automatic clr_all();
    irq_clr = 2'b11; step("R8 clear");
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 en", en_rd_data, 8'h00);
    check("R1 pend", {6'b0, irq_pend}, 8'h00);

    // R2 reserved bits dropped
    wr_en(8'hFF);
    check("R2 readback", en_rd_data, 8'h07);

    // R7 all sources with every gate closed
    wr_en(8'hF8);
    ev_setup = 1; ev_zlp = 1; ev_in_ack = 1; ev_out = 2'b11; ev_crc_ok = 2'b11;
    ev_nak_in = 2'b11; ev_nak_out = 2'b11;
    step("R7 gated");
    check("R7 nothing pending", {6'b0, irq_pend}, 8'h00);

    // R3 SETUP then clear (R8), then ZLP
    wr_en(8'h01);
    ev_setup = 1; step("R3 setup");
    check("R3 setup flag", {6'b0, irq_pend}, 8'h01);
    step("R8 hold");
    check("R8 hold flag", {6'b0, irq_pend}, 8'h01);
    irq_clr = 2'b10; step("R8 other clear");
    check("R8 other clear", {6'b0, irq_pend}, 8'h01);
    irq_clr = 2'b01; step("R8 own clear");
    check("R8 own clear", {6'b0, irq_pend}, 8'h00);
    ev_zlp = 1; step("R3 zlp");
    check("R3 zlp flag", {6'b0, irq_pend}, 8'h01);
    clr_all();

    // R4 bad CRC with and without ACK-OUT mode
    ev_out = 2'b01; step("R4 bad crc");
    check("R4 bad crc no flag", {6'b0, irq_pend}, 8'h00);
    ev_out = 2'b01; ack_out_mode = 2'b01; step("R4 ackout");
    check("R4 ackout flag", {6'b0, irq_pend}, 8'h01);
    ack_out_mode = '0; clr_all();

    // R5/R6 split EP1 enables
    wr_en(8'h02);
    ev_nak_out = 2'b10; ev_out = 2'b10; ev_crc_ok = 2'b10; step("R5 out side gated");
    check("R5 ep1 out gated", {6'b0, irq_pend}, 8'h00);
    ev_in_ack = 1; step("R6 in ack");
    check("R6 in ack flag", {6'b0, irq_pend}, 8'h02);
    clr_all();
    wr_en(8'h04);
    ev_nak_in = 2'b10; ev_in_ack = 1; step("R6 in side gated");
    check("R6 ep1 in gated", {6'b0, irq_pend}, 8'h00);
    ev_nak_out = 2'b10; step("R5 nak out");
    check("R5 ep1 nak out flag", {6'b0, irq_pend}, 8'h02);

    // R9 event and clear together
    ev_nak_out = 2'b10; irq_clr = 2'b10; step("R9 event wins");
    check("R9 stays set", {6'b0, irq_pend}, 8'h02);
    clr_all();

    // R10 write in same cycle as event uses old enable
    en_wr = 1; en_wr_data = 8'h01; ev_setup = 1; step("R10 same cycle");
    check("R10 old enable used", {6'b0, irq_pend}, 8'h00);
    en_wr = 1; en_wr_data = 8'h00; ev_setup = 1; step("R10 old enable set");
    check("R10 fires on old", {6'b0, irq_pend}, 8'h01);
    clr_all();

    // R11 merged events, one clear
    wr_en(8'h07);
    ev_setup = 1; ev_zlp = 1; ev_nak_in = 2'b01; step("R11 burst a");
    ev_nak_out = 2'b01; step("R11 burst b");
    irq_clr = 2'b01; step("R11 single clear");
    check("R11 cleared once", {6'b0, irq_pend}, 8'h00);

    // random mix covering R3 R4 R5 R6 R8 R9 R2
    for (int k = 0; k < N_RANDOM; k++) begin
      en_wr        = ($urandom % 16) == 0;
      en_wr_data   = 8'($urandom);
      ev_setup     = ($urandom % 8) == 0;
      ev_zlp       = ($urandom % 8) == 0;
      ev_in_ack    = ($urandom % 8) == 0;
      ev_out       = 2'($urandom) & 2'($urandom);
      ev_crc_ok    = 2'($urandom);
      ack_out_mode = 2'($urandom);
      ev_nak_in    = 2'($urandom) & 2'($urandom) & 2'($urandom);
      ev_nak_out   = 2'($urandom) & 2'($urandom) & 2'($urandom);
      irq_clr      = 2'($urandom);
      step("R3/R4/R5/R6/R8/R9 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule